// File: doc/BRIEF.md
# List-Mode Event Histogrammer

This block builds pulse-height spectra from the word stream of zero-suppressed digitizers. Each strobe carries one 16-bit word. A word is either a header that names the sending station or a data record that carries a subaddress and a conversion value. The block keeps the match result of the most recent header. Every record that follows a matching header is turned into a channel address, and the 24-bit count at that address is incremented through a read-modify-write on an external single-port memory.

The 32768-channel memory is shared between two stations. When both station comparators are enabled, the first station owns the lower half and the second station owns the upper half. When only the first comparator is enabled, the first station owns the whole memory. A configuration field splits the memory into 2 to 32 equal segments. Within a station's space, the segments are handed out in order of subaddress. An overflow flag tells the host that a channel has reached full scale.

Top module: `list_histogrammer`

## Requirements
- R1: A word with bit 15 set is a header whose station number is bits 7:0. Bits 14:8 of a header are ignored. A header never causes a memory access. A word with bit 15 clear is a data record whose subaddress is bits 14:10 and whose conversion value is bits 9:0.
- R2: Each header replaces the stored match state. Records are histogrammed only while the most recent header matched an enabled comparator. Records that arrive after reset and before any header, or after a non-matching header, are dropped. The match state persists across any number of records.
- R3: Configuration bit 0 enables the comparator for station register 1, and bit 1 enables the comparator for station register 2. A disabled comparator never matches. With both enabled, station 1 records land in the lower half (address bit 14 = 0) and station 2 records land in the upper half (bit 14 = 1). When a header matches both registers, station 1 wins.
- R4: With comparator 2 disabled, station 1 records span the whole 15-bit address space, and address bit 14 comes from the segment number.
- R5: Configuration bits 4:2 form a code k that is clamped to at most 4. The memory holds 2^(k+1) segments of 2^(14-k) channels each. The address is {half, segment, 0...} + conversion value, where the segment field is placed at bit 14-k.
- R6: Each station owns 2^k segments when both comparators are enabled, and 2^(k+1) segments when comparator 2 is disabled. The segment is the subaddress modulo that count.
- R7: A record is taken only when ready is high. The read strobe is asserted in the cycle after acceptance. The write strobe and the one-cycle stored pulse follow in the next cycle, with the same address. Ready is low during both cycles, and strobes seen while ready is low are ignored.
- R8: The written value is the read value plus one. A channel already at 0xFFFFFF stays at 0xFFFFFF.
- R9: The overflow flag is set when a write finds its channel at 0xFFFFFF while the overflow enable is high. The flag is held clear while the enable is low.
- R10: A start pulse turns analyze on and a stop pulse turns it off. Stop wins when both pulses arrive together. A record is stored only if analyze is on and inhibit is low in the cycle it is accepted.
- R11: Reset clears analyze, the overflow flag and the match state, and leaves the block idle with ready high and no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 16 | Header or data record |
| strobe_i | input | 1 | Word valid |
| ready_o | output | 1 | Block can accept a word |
| start_i | input | 1 | Start analyze pulse |
| stop_i | input | 1 | Stop analyze pulse |
| inhibit_i | input | 1 | Suppresses storing while high |
| cfg_i | input | 5 | Comparator enables [1:0], segment code [4:2] |
| stn1_i | input | 8 | Station register 1 |
| stn2_i | input | 8 | Station register 2 |
| lam_en_i | input | 1 | Overflow flag enable |
| analyze_o | output | 1 | Analyze state |
| mem_addr_o | output | 15 | Channel address |
| mem_rd_o | output | 1 | Read strobe, data expected next cycle |
| mem_rdata_i | input | 24 | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 24 | Incremented count |
| lam_o | output | 1 | Overflow flag |
| stored_o | output | 1 | One-cycle stored pulse |

## Verification
The assertions check the following on every cycle:
- every read is followed by a write to the same address;
- a written count is never zero, so a full channel never wraps;
- a read only follows acceptance while analyze was on and inhibit was low;
- the overflow flag rises only after a write of full scale and stays low while disabled.

Several behaviours can only be shown by the bench's scenarios: the address arithmetic for each segment code and comparator setting, the sticky header match, priority between equal station registers, and strobes dropped while busy. The bench shows them by comparing the observed addresses and counts with values worked out from the requirements.

// File: rtl/list_histogrammer.sv
module list_histogrammer #(
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 24,
  parameter int ADDR_W   = 15,
  parameter int STN_W    = 8,
  parameter int SUB_W    = 5,
  parameter int CONV_W   = 10,
  parameter int CODE_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              strobe_i,
  output logic              ready_o,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              inhibit_i,
  input  logic [4:0]        cfg_i,
  input  logic [STN_W-1:0]  stn1_i,
  input  logic [STN_W-1:0]  stn2_i,
  input  logic              lam_en_i,
  output logic              analyze_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [CNT_W-1:0]  mem_rdata_i,
  output logic              mem_wr_o,
  output logic [CNT_W-1:0]  mem_wdata_o,
  output logic              lam_o,
  output logic              stored_o
);
  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic match_v, match_hi, analyze_q, lam_q;
  logic [ADDR_W-1:0] addr_q;

  wire accept = strobe_i && (st == IDLE);
  wire is_hdr = word_i[WORD_W-1];
  wire [STN_W-1:0] stn = word_i[STN_W-1:0];
  wire hit1 = cfg_i[0] && (stn == stn1_i);
  wire hit2 = cfg_i[1] && (stn == stn2_i);

  wire [2:0] code = (cfg_i[4:2] > 3'(CODE_MAX)) ? 3'(CODE_MAX) : cfg_i[4:2];
  wire [3:0] seg_bits = {1'b0, code} + {3'b000, ~cfg_i[1]};
  wire [3:0] off_bits = 4'(ADDR_W - 1) - {1'b0, code};

  wire [SUB_W-1:0]  sub      = word_i[CONV_W +: SUB_W];
  wire [ADDR_W-1:0] conv     = ADDR_W'(word_i[CONV_W-1:0]);
  wire [ADDR_W-1:0] seg_mask = (ADDR_W'(1) << seg_bits) - ADDR_W'(1);
  wire [ADDR_W-1:0] seg      = ADDR_W'(sub) & seg_mask;
  wire [ADDR_W-1:0] half     = (cfg_i[1] && match_hi) ? (ADDR_W'(1) << (ADDR_W - 1)) : '0;
  wire [ADDR_W-1:0] rec_addr = half | (seg << off_bits) | conv;

  wire go   = accept && !is_hdr && match_v && analyze_q && !inhibit_i;
  wire full = (mem_rdata_i == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      match_v   <= 1'b0;
      match_hi  <= 1'b0;
      analyze_q <= 1'b0;
      lam_q     <= 1'b0;
      addr_q    <= '0;
    end else begin
      if (stop_i) analyze_q <= 1'b0;
      else if (start_i) analyze_q <= 1'b1;

      if (accept && is_hdr) begin
        match_v  <= hit1 || hit2;
        match_hi <= !hit1 && hit2;
      end

      if (!lam_en_i) lam_q <= 1'b0;
      else if (st == WR && full) lam_q <= 1'b1;

      case (st)
        IDLE: if (go) begin
          addr_q <= rec_addr;
          st     <= RD;
        end
        RD:      st <= WR;
        default: st <= IDLE;
      endcase
    end
  end

  assign ready_o     = (st == IDLE);
  assign mem_rd_o    = (st == RD);
  assign mem_wr_o    = (st == WR);
  assign stored_o    = (st == WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = full ? mem_rdata_i : mem_rdata_i + CNT_W'(1);
  assign analyze_o   = analyze_q;
  assign lam_o       = lam_q;
endmodule

// File: rtl/list_histogrammer_chk.sv
module list_histogrammer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inhibit_i,
  input logic              lam_en_i,
  input logic              analyze_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [CNT_W-1:0]  mem_wdata_o,
  input logic              lam_o
);
  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> mem_wr_o && $stable(mem_addr_o));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> mem_wdata_o != '0);

  // R10
  store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> $past(analyze_o) && !$past(inhibit_i));

  // R9
  lam_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lam_o) |-> $past(mem_wr_o) && $past(mem_wdata_o) == {CNT_W{1'b1}} && $past(lam_en_i));

  // R9
  lam_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lam_en_i |=> !lam_o);
endmodule

bind list_histogrammer list_histogrammer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .lam_en_i(lam_en_i),
  .analyze_o(analyze_o), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .lam_o(lam_o)
);

// File: tb/tb_list_histogrammer.sv
module tb_list_histogrammer;
  localparam int CLK_P = 10;
  localparam int NV = 16;
  // {cfg[4:0], word[15:0], expect_store, expect_addr[14:0]}
  localparam logic [36:0] VEC [NV] = '{
    {5'b01011, 16'h0C05, 1'b0, 15'h0000},  // R2 before header
    {5'b01011, 16'hB821, 1'b0, 15'h0000},  // R1 header, count bits ignored
    {5'b01011, 16'h0405, 1'b1, 15'h1005},  // R5
    {5'b01011, 16'h1BFF, 1'b1, 15'h23FF},  // R6 sub 6 mod 4
    {5'b01011, 16'h8042, 1'b0, 15'h0000},
    {5'b01011, 16'h0C07, 1'b1, 15'h7007},  // R3 upper half
    {5'b01011, 16'h8055, 1'b0, 15'h0000},
    {5'b01011, 16'h0405, 1'b0, 15'h0000},  // R2 no match
    {5'b00001, 16'h8042, 1'b0, 15'h0000},  // R3 comparator 2 off
    {5'b00001, 16'h0405, 1'b0, 15'h0000},
    {5'b00001, 16'hA021, 1'b0, 15'h0000},
    {5'b00001, 16'h0409, 1'b1, 15'h4009},  // R4 whole memory
    {5'b00001, 16'h0809, 1'b1, 15'h0009},  // R6 sub 2 mod 2
    {5'b11101, 16'h7C01, 1'b1, 15'h7C01},  // R5 code clamp
    {5'b10011, 16'h8042, 1'b0, 15'h0000},
    {5'b10011, 16'h4402, 1'b1, 15'h4402}   // R6 sub 17 mod 16
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] word = '0;
  logic strobe = 0, start = 0, stop = 0, inhibit = 0, lam_en = 0;
  logic [4:0] cfg = 5'b01011;
  logic [7:0] stn1 = 8'h21, stn2 = 8'h42;
  logic [23:0] rdata = '0;
  logic ready_o, analyze_o, mem_rd_o, mem_wr_o, lam_o, stored_o;
  logic [14:0] mem_addr_o;
  logic [23:0] mem_wdata_o;
  logic [23:0] mem [int];
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  list_histogrammer dut (
    .clk(clk), .rst_n(rst_n), .word_i(word), .strobe_i(strobe), .ready_o(ready_o),
    .start_i(start), .stop_i(stop), .inhibit_i(inhibit), .cfg_i(cfg),
    .stn1_i(stn1), .stn2_i(stn2), .lam_en_i(lam_en), .analyze_o(analyze_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(rdata),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .lam_o(lam_o), .stored_o(stored_o)
  );

  always @(posedge clk) begin
    if (mem_rd_o) rdata <= mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 24'h0;
    if (mem_wr_o) mem[int'(mem_addr_o)] = mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [15:0] w, output bit rd, output bit wr,
                      output logic [14:0] a, output logic [23:0] d, output bit rdy);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    word = w; strobe = 1;
    @(negedge clk);
    strobe = 0; rd = mem_rd_o; a = mem_addr_o; rdy = ready_o;
    @(negedge clk);
    wr = mem_wr_o && stored_o; d = mem_wdata_o;
  endtask

  task automatic pulse(input bit s, input bit p);
    @(negedge clk); start = s; stop = p;
    @(negedge clk); start = 0; stop = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    bit rd, wr, rdy;
    logic [14:0] a;
    logic [23:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(ready_o && !analyze_o && !lam_o && !mem_rd_o && !mem_wr_o && !stored_o,
        "R11 reset", {ready_o, analyze_o, lam_o, mem_rd_o, mem_wr_o, stored_o}, 6'b100000);

    lam_en = 1;
    pulse(1, 0);
    chk(analyze_o, "R10 start", analyze_o, 1);

    for (int i = 0; i < NV; i++) begin
      cfg = VEC[i][36:32];
      send(VEC[i][31:16], rd, wr, a, d, rdy);
      chk(rd == VEC[i][15] && wr == VEC[i][15], "R1 R2 R3 R4 store decision",
          {rd, wr}, {VEC[i][15], VEC[i][15]});
      if (VEC[i][15]) begin
        chk(a == VEC[i][14:0], "R5 R6 address", a, VEC[i][14:0]);
        chk(!rdy, "R7 ready low while busy", rdy, 0);
      end
    end

    cfg = 5'b01011;
    send(16'h8021, rd, wr, a, d, rdy);
    send(16'h0405, rd, wr, a, d, rdy);
    chk(wr && a == 15'h1005 && d == 24'd2, "R7 increment", d, 24'd2);

    mem[int'(15'h1006)] = 24'hFFFFFE;
    send(16'h0406, rd, wr, a, d, rdy);
    chk(d == 24'hFFFFFF, "R8 reach full", d, 24'hFFFFFF);
    @(negedge clk);
    chk(!lam_o, "R9 no flag below full", lam_o, 0);
    send(16'h0406, rd, wr, a, d, rdy);
    chk(wr && d == 24'hFFFFFF, "R8 saturate", d, 24'hFFFFFF);
    @(negedge clk);
    chk(lam_o, "R9 flag on overflow", lam_o, 1);
    lam_en = 0;
    @(negedge clk);
    chk(!lam_o, "R9 flag cleared by disable", lam_o, 0);
    send(16'h0406, rd, wr, a, d, rdy);
    @(negedge clk);
    chk(!lam_o, "R9 no flag while disabled", lam_o, 0);
    lam_en = 1;

    // R3 priority with equal registers
    stn2 = 8'h21;
    send(16'h8021, rd, wr, a, d, rdy);
    send(16'h0001, rd, wr, a, d, rdy);
    chk(wr && a == 15'h0001, "R3 station 1 priority", a, 15'h0001);
    stn2 = 8'h42;

    // R7 strobe while busy is ignored
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    word = 16'h0002; strobe = 1;
    @(negedge clk);
    word = 16'h8055;
    @(negedge clk);
    strobe = 0;
    send(16'h0003, rd, wr, a, d, rdy);
    chk(rd && wr && a == 15'h0003, "R7 busy strobe ignored", a, 15'h0003);

    // R10 inhibit
    inhibit = 1;
    send(16'h0004, rd, wr, a, d, rdy);
    chk(!rd && !wr, "R10 inhibit blocks", {rd, wr}, 0);
    inhibit = 0;

    pulse(0, 1);
    chk(!analyze_o, "R10 stop", analyze_o, 0);
    send(16'h0005, rd, wr, a, d, rdy);
    chk(!rd && !wr, "R10 no store when stopped", {rd, wr}, 0);
    pulse(1, 1);
    chk(!analyze_o, "R10 stop wins", analyze_o, 0);
    pulse(1, 0);
    send(16'h0005, rd, wr, a, d, rdy);
    chk(wr && a == 15'h0005 && d == 24'd1, "R10 restart stores", d, 24'd1);

    report();
  end
endmodule